// File: doc/BRIEF.md
# Wormhole Virtual-Channel Mesh Router

This block is the switching element for one node of a 3x3 two-dimensional mesh. It has five physical ports: the local node and the four mesh neighbours. Each input port is split into two virtual channels. Each virtual channel has its own four-entry flit buffer and its own ready line back to the sender. Packets travel as flits under wormhole flow control. A head flit carries the destination coordinates and reserves an output virtual channel. Body flits follow on that reservation, and the tail flit releases it.

For every buffered head flit, the router computes the output port by X-then-Y dimension-order routing. It selects a free downstream virtual channel with the help of saturating load counters. A round-robin arbiter per output port picks one winner among the ten input virtual channels. The winning flit is presented on the output in the cycle after it was buffered, so an uncontended hop costs one clock.

Both stream sides use valid/ready with a per-virtual-channel ready. On the input side, the sender presents `in_valid`, `in_vc` and `in_flit` for a port. The flit is taken on a rising edge where the ready bit of the addressed virtual channel is high. A sender is not required to hold a flit that was not taken. On the output side, the router asserts `out_valid` for a port only when the downstream ready bit for the virtual channel on `out_vc` is high. Every presented flit is therefore transferred on the next edge, and downstream back-pressure simply keeps `out_valid` low.

Top module: `mesh_vc_router`

## Requirements
- R1: After reset, every `out_valid` bit is low and every `in_ready` bit is high.
- R2: Input virtual channel v of port p (index 2p+v) buffers up to four flits. `in_ready[2p+v]` is high exactly when that buffer is not full. A flit is written only when `in_valid[p]` is high, `in_vc[p]` equals v and the ready bit is high. A flit offered while the ready bit is low is ignored.
- R3: A flit is 16 bits. Bits [15:14] hold the type: 00 body, 01 head, 10 tail, 11 single (head and tail at once). In a head or single flit, bits [1:0] give the destination X and bits [3:2] give the destination Y.
- R4: The output port is chosen by dimension order. Ports are numbered 0 local, 1 east (X+1), 2 west (X-1), 3 north (Y+1), 4 south (Y-1). X is corrected first; Y moves only once X matches; a flit whose X and Y both match the node leaves on the local port.
- R5: A flit written on a rising edge, when it meets no contention, is presented on its output in the following cycle. A stream of flits through one port moves at one flit per cycle.
- R6: `out_valid[p]` is high only when `out_ready[2p+out_vc[p]]` is high. A presented flit is transferred on the next rising edge.
- R7: A head flit reserves its output virtual channel. Body and tail flits of that packet leave on the same port and virtual channel. No other head uses that channel until the tail has left, which frees it.
- R8: A head picks a free output virtual channel. When both are free, it takes channel 1 only if channel 1's load count is strictly lower than channel 0's; otherwise it takes channel 0. A channel's 3-bit load count rises by one, saturating at 7, in each cycle it is reserved and its next flit waits for a low downstream ready. The count falls by one, stopping at 0, in each cycle the channel is not reserved.
- R9: Each output port grants the lowest-numbered requesting input virtual channel (index 2p+v), counting on from the one just after its previous winner. Its first grant after reset starts from index 0.
- R10: A body or tail flit that reaches the front of an input virtual channel with no reservation is discarded, and the flits behind it move on.
- R11: A single flit is forwarded without leaving any reservation behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 5 | Flit offered on input port p |
| in_vc | input | 5 | Virtual channel addressed by the offered flit, per port |
| in_flit | input | 80 | Offered flits, port p in bits [16p+15:16p] |
| in_ready | output | 10 | Buffer of input virtual channel 2p+v can take a flit |
| out_valid | output | 5 | Flit presented on output port p |
| out_vc | output | 5 | Downstream virtual channel of the presented flit, per port |
| out_flit | output | 80 | Presented flits, port p in bits [16p+15:16p] |
| out_ready | input | 10 | Downstream buffer 2p+v can take a flit |

## Verification
On every cycle, the assertions check the following:
- presented flits only go to a ready downstream channel;
- every head leaves in the direction that dimension order allows;
- heads and non-heads alternate correctly per output virtual channel;
- an input ready bit only falls right after a write to that channel;
- outputs are quiet in reset.

Only the directed scenarios can show the rest:
- the one-cycle hop and the one-flit-per-cycle rate;
- the exact round-robin grant order;
- the load-driven choice of channel 1 after a stall;
- discard of stray body flits;
- that a rejected flit never appears downstream.

// File: rtl/mvr_pkg.sv
package mvr_pkg;

  localparam int NUM_PORTS = 5;
  localparam int NUM_VCS   = 2;
  localparam int PORT_W    = 3;

  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } ftype_e;

  localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd1;
  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd2;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd3;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd4;

  // X is resolved before Y; equal coordinates go to the local port
  function automatic logic [PORT_W-1:0] dor_port(input int cx, input int cy,
                                                 input int dx, input int dy);
    if (dx > cx)      return PORT_EAST;
    else if (dx < cx) return PORT_WEST;
    else if (dy > cy) return PORT_NORTH;
    else if (dy < cy) return PORT_SOUTH;
    else              return PORT_LOCAL;
  endfunction

endpackage

// File: rtl/mvr_vc_fifo.sv
module mvr_vc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/mvr_rr_arb.sv
module mvr_rr_arb #(
  parameter int N  = 10,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] ptr_q;

  always_comb begin : scan
    int idx;
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        grant[idx] = 1'b1;
        gidx       = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
  end
endmodule

// File: rtl/mvr_ovc_load.sv
module mvr_ovc_load #(
  parameter int LOAD_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] owned,
  input  logic [1:0] stall,
  output logic       pick,
  output logic       has_free
);
  localparam logic [LOAD_W-1:0] LOAD_MAX = '1;

  logic [LOAD_W-1:0] cnt_q [2];

  for (genvar v = 0; v < 2; v++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[v] <= '0;
      else if (stall[v]) begin
        if (cnt_q[v] != LOAD_MAX) cnt_q[v] <= cnt_q[v] + 1'b1;
      end else if (!owned[v]) begin
        if (cnt_q[v] != '0) cnt_q[v] <= cnt_q[v] - 1'b1;
      end
    end
  end

  always_comb begin
    has_free = ~&owned;
    if (owned == 2'b00) pick = (cnt_q[1] < cnt_q[0]);
    else                pick = owned[0];
  end
endmodule

// File: rtl/mesh_vc_router.sv
module mesh_vc_router
  import mvr_pkg::*;
#(
  parameter int FLIT_W     = 16,
  parameter int COORD_W    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int LOAD_W     = 3,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          in_valid,
  input  logic [NUM_PORTS-1:0]          in_vc,
  input  logic [NUM_PORTS*FLIT_W-1:0]   in_flit,
  output logic [NUM_PORTS*NUM_VCS-1:0]  in_ready,
  output logic [NUM_PORTS-1:0]          out_valid,
  output logic [NUM_PORTS-1:0]          out_vc,
  output logic [NUM_PORTS*FLIT_W-1:0]   out_flit,
  input  logic [NUM_PORTS*NUM_VCS-1:0]  out_ready
);
  localparam int NP = NUM_PORTS;
  localparam int NV = NUM_VCS;
  localparam int NI = NP * NV;
  localparam int PW = PORT_W;
  localparam int IW = $clog2(NI);
  localparam int TB = FLIT_W - 2;

  logic [FLIT_W-1:0] hd [NI];
  logic [1:0]        ft [NI];
  logic [NI-1:0]     f_empty, f_full, f_push, f_pop;

  logic [NI-1:0]     routed_q, rvc_q;
  logic [PW-1:0]     rport_q [NI];

  logic [PW-1:0]     tp [NI];
  logic [NI-1:0]     tv, elig, drop;

  logic [NI-1:0]     owned_q, own_set, own_clr, stall;
  logic [NP-1:0]     pick_vc, has_free;

  logic [NI-1:0]     req_p   [NP];
  logic [NI-1:0]     grant_p [NP];
  logic [IW-1:0]     gidx_p  [NP];
  logic [NP-1:0]     gany;

  // ingress buffers, one per input virtual channel
  for (genvar i = 0; i < NI; i++) begin : g_in
    localparam int IP = i / NV;
    localparam int VV = i % NV;
    assign f_push[i]   = in_valid[IP] && (in_vc[IP] == 1'(VV)) && !f_full[i];
    assign in_ready[i] = !f_full[i];
    mvr_vc_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push[i]),
      .din   (in_flit[IP*FLIT_W +: FLIT_W]),
      .pop   (f_pop[i]),
      .dout  (hd[i]),
      .empty (f_empty[i]),
      .full  (f_full[i])
    );
  end

  // route computation and per-input eligibility
  always_comb begin : route_calc
    logic [PW-1:0] dr;
    for (int i = 0; i < NI; i++) begin
      ft[i] = hd[i][TB +: 2];
      dr    = dor_port(MY_X, MY_Y, int'(hd[i][COORD_W-1:0]),
                       int'(hd[i][2*COORD_W-1:COORD_W]));
      tp[i]   = routed_q[i] ? rport_q[i] : dr;
      tv[i]   = routed_q[i] ? rvc_q[i]   : pick_vc[dr];
      elig[i] = !f_empty[i] && (routed_q[i] || (ft[i][0] && has_free[dr]))
                && out_ready[{tp[i], tv[i]}];
      drop[i] = !f_empty[i] && !routed_q[i] && !ft[i][0];
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NI; i++)
        req_p[p][i] = elig[i] && (tp[i] == PW'(p));
  end

  // switch allocation and crossbar, one arbiter per output port
  for (genvar p = 0; p < NP; p++) begin : g_out
    mvr_rr_arb #(.N(NI), .IW(IW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_p[p]),
      .grant (grant_p[p]),
      .gidx  (gidx_p[p]),
      .any   (gany[p])
    );
    mvr_ovc_load #(.LOAD_W(LOAD_W)) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .owned    (owned_q[p*NV +: NV]),
      .stall    (stall[p*NV +: NV]),
      .pick     (pick_vc[p]),
      .has_free (has_free[p])
    );
    assign out_valid[p]                = gany[p];
    assign out_vc[p]                   = tv[gidx_p[p]];
    assign out_flit[p*FLIT_W +: FLIT_W] = hd[gidx_p[p]];
  end

  always_comb begin
    for (int i = 0; i < NI; i++) begin
      f_pop[i] = drop[i];
      for (int p = 0; p < NP; p++)
        if (grant_p[p][i]) f_pop[i] = 1'b1;
    end
  end

  // output virtual channel reservation and load stall detection
  always_comb begin : ovc_track
    logic [IW-1:0] w;
    logic [IW-1:0] o;
    own_set = '0;
    own_clr = '0;
    for (int p = 0; p < NP; p++) begin
      w = gidx_p[p];
      o = {PW'(p), tv[w]};
      if (gany[p] && ft[w] == FT_HEAD) own_set[o] = 1'b1;
      if (gany[p] && ft[w] == FT_TAIL) own_clr[o] = 1'b1;
    end
    stall = '0;
    for (int i = 0; i < NI; i++) begin
      o = {rport_q[i], rvc_q[i]};
      if (routed_q[i] && !f_empty[i] && owned_q[o] && !out_ready[o])
        stall[o] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owned_q <= '0;
    else        owned_q <= (owned_q | own_set) & ~own_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      routed_q <= '0;
      rvc_q    <= '0;
      for (int i = 0; i < NI; i++) rport_q[i] <= '0;
    end else begin
      for (int i = 0; i < NI; i++) begin
        if (f_pop[i] && !drop[i]) begin
          if (ft[i] == FT_HEAD) begin
            routed_q[i] <= 1'b1;
            rport_q[i]  <= tp[i];
            rvc_q[i]    <= tv[i];
          end else if (ft[i] == FT_TAIL) begin
            routed_q[i] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mvr_router_chk.sv
module mvr_router_chk #(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 2,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  in_valid,
  input logic [4:0]  in_vc,
  input logic [9:0]  in_ready,
  input logic [4:0]  out_valid,
  input logic [4:0]  out_vc,
  input logic [5*FLIT_W-1:0] out_flit,
  input logic [9:0]  out_ready
);
  localparam int TB = FLIT_W - 2;

  function automatic logic dir_ok(input int p, input int dx, input int dy);
    case (p)
      0:       return dx == MY_X && dy == MY_Y;
      1:       return dx > MY_X;
      2:       return dx < MY_X;
      3:       return dx == MY_X && dy > MY_Y;
      default: return dx == MY_X && dy < MY_Y;
    endcase
  endfunction

  logic [9:0] open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= '0;
    else begin
      for (int p = 0; p < 5; p++) begin
        if (out_valid[p] && out_ready[2*p + int'(out_vc[p])]) begin
          if (out_flit[p*FLIT_W + TB +: 2] == 2'b01) open_q[2*p + int'(out_vc[p])] <= 1'b1;
          if (out_flit[p*FLIT_W + TB +: 2] == 2'b10) open_q[2*p + int'(out_vc[p])] <= 1'b0;
        end
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> out_valid == '0); // R1

  for (genvar p = 0; p < 5; p++) begin : g_port
    AST_XFER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> out_ready[2*p + int'(out_vc[p])]); // R6
    AST_DOR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && out_flit[p*FLIT_W + TB]) |->
        dir_ok(p, int'(out_flit[p*FLIT_W +: COORD_W]),
               int'(out_flit[p*FLIT_W + COORD_W +: COORD_W]))); // R4
    AST_HEAD_ON_FREE_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && out_flit[p*FLIT_W + TB]) |-> !open_q[2*p + int'(out_vc[p])]); // R7
    AST_BODY_ON_OPEN_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && !out_flit[p*FLIT_W + TB]) |-> open_q[2*p + int'(out_vc[p])]); // R7
  end

  for (genvar i = 0; i < 10; i++) begin : g_vc
    AST_READY_FALL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready[i]) |-> $past(in_valid[i/2] && in_vc[i/2] == 1'(i%2))); // R2
  end
endmodule

bind mesh_vc_router mvr_router_chk #(
  .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
  .in_ready(in_ready), .out_valid(out_valid), .out_vc(out_vc),
  .out_flit(out_flit), .out_ready(out_ready)
);

// File: tb/sim_mesh_vc_router.sv
`timescale 1ns/1ps
module sim_mesh_vc_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  in_valid = '0;
  logic [4:0]  in_vc = '0;
  logic [79:0] in_flit = '0;
  logic [9:0]  in_ready;
  logic [4:0]  out_valid;
  logic [4:0]  out_vc;
  logic [79:0] out_flit;
  logic [9:0]  out_ready = '1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  int          lg_n = 0;
  int          lg_port [64];
  logic        lg_vc   [64];
  logic [15:0] lg_flit [64];
  int          lg_cyc  [64];

  always #4 clk = ~clk;

  mesh_vc_router u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_flit(in_flit), .in_ready(in_ready), .out_valid(out_valid),
    .out_vc(out_vc), .out_flit(out_flit), .out_ready(out_ready)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // record every transfer, sampled well after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int p = 0; p < 5; p++) begin
        if (out_valid[p] && out_ready[2*p + int'(out_vc[p])] && lg_n < 64) begin
          lg_port[lg_n] = p;
          lg_vc[lg_n]   = out_vc[p];
          lg_flit[lg_n] = out_flit[p*16 +: 16];
          lg_cyc[lg_n]  = cyc;
          lg_n++;
        end
      end
    end
  end

  function automatic logic [15:0] mk(input logic [1:0] t, input int dx,
                                     input int dy, input int pl);
    return {t, 10'(pl), 2'(dy), 2'(dx)};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic set_in(input int p, input logic vc, input logic [15:0] f);
    in_valid[p]       = 1'b1;
    in_vc[p]          = vc;
    in_flit[p*16 +: 16] = f;
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    out_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lg_n = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out_valid", 32'(out_valid), 32'h0);
    chk("R1 in_ready", 32'(in_ready), 32'h3ff);
  endtask

  task automatic t_route();
    int dx [7] = '{2, 0, 1, 1, 1, 2, 0};
    int dy [7] = '{1, 1, 2, 0, 1, 2, 0};
    int ep [7] = '{1, 2, 3, 4, 0, 1, 2};
    int c0;
    do_reset();
    c0 = cyc;
    for (int k = 0; k < 7; k++) begin
      set_in(0, 1'b0, mk(2'b11, dx[k], dy[k], k + 1));
      step();
    end
    idle(3);
    chk("R4 count", 32'(lg_n), 32'd7);
    for (int k = 0; k < 7; k++) begin
      chk("R4 port", 32'(lg_port[k]), 32'(ep[k]));
      chk("R3 flit", 32'(lg_flit[k]), 32'(mk(2'b11, dx[k], dy[k], k + 1)));
    end
    chk("R5 first hop", 32'(lg_cyc[0]), 32'(c0 + 1));
    chk("R5 rate", 32'(lg_cyc[6]), 32'(c0 + 7));
  endtask

  task automatic t_worm();
    do_reset();
    set_in(0, 1'b0, mk(2'b01, 2, 1, 1));
    set_in(3, 1'b0, mk(2'b01, 2, 1, 2));
    step();
    set_in(0, 1'b0, mk(2'b00, 0, 0, 3));
    set_in(3, 1'b0, mk(2'b10, 0, 0, 4));
    step();
    set_in(0, 1'b0, mk(2'b10, 0, 0, 5));
    step();
    idle(4);
    set_in(2, 1'b0, mk(2'b11, 2, 1, 6));
    step();
    idle(2);
    set_in(4, 1'b1, mk(2'b01, 2, 0, 7));
    step();
    set_in(4, 1'b1, mk(2'b10, 0, 0, 8));
    step();
    idle(3);
    chk("R7 count", 32'(lg_n), 32'd8);
    // R9 order: local head, north head, local body, north tail, local tail
    chk("R9 seq0", 32'({lg_vc[0], lg_flit[0][13:4]}), 32'({1'b0, 10'd1}));
    chk("R7 seq1", 32'({lg_vc[1], lg_flit[1][13:4]}), 32'({1'b1, 10'd2}));
    chk("R9 seq2", 32'({lg_vc[2], lg_flit[2][13:4]}), 32'({1'b0, 10'd3}));
    chk("R7 seq3", 32'({lg_vc[3], lg_flit[3][13:4]}), 32'({1'b1, 10'd4}));
    chk("R7 seq4", 32'({lg_vc[4], lg_flit[4][13:4]}), 32'({1'b0, 10'd5}));
    chk("R7 released vc0", 32'({lg_vc[5], lg_flit[5][13:4]}), 32'({1'b0, 10'd6}));
    chk("R11 single no hold", 32'({lg_vc[6], lg_flit[6][13:4]}), 32'({1'b0, 10'd7}));
    chk("R7 tail port", 32'(lg_port[7]), 32'd1);
  endtask

  task automatic t_rr();
    do_reset();
    out_ready[3:2] = 2'b00;
    set_in(0, 1'b0, mk(2'b11, 2, 1, 11));
    set_in(3, 1'b0, mk(2'b11, 2, 1, 21));
    step();
    set_in(0, 1'b0, mk(2'b11, 2, 1, 12));
    step();
    set_in(0, 1'b0, mk(2'b11, 2, 1, 13));
    step();
    chk("R6 blocked", 32'(out_valid[1]), 32'h0);
    out_ready[3:2] = 2'b11;
    idle(6);
    chk("R9 count", 32'(lg_n), 32'd4);
    chk("R9 first", 32'(lg_flit[0][13:4]), 32'd11);
    chk("R9 second", 32'(lg_flit[1][13:4]), 32'd21);
    chk("R9 third", 32'(lg_flit[2][13:4]), 32'd12);
    chk("R9 fourth", 32'(lg_flit[3][13:4]), 32'd13);
  endtask

  task automatic t_load();
    do_reset();
    set_in(0, 1'b0, mk(2'b01, 2, 1, 31));
    step();
    set_in(0, 1'b0, mk(2'b00, 0, 0, 32));
    step();
    out_ready[2] = 1'b0;
    set_in(0, 1'b0, mk(2'b10, 0, 0, 33));
    step();
    idle(4);
    out_ready[2] = 1'b1;
    step();
    set_in(3, 1'b0, mk(2'b11, 2, 1, 41));
    step();
    idle(4);
    chk("R8 count", 32'(lg_n), 32'd4);
    chk("R8 packet vc", 32'({lg_vc[0], lg_vc[1], lg_vc[2]}), 32'h0);
    chk("R8 tail flit", 32'(lg_flit[2][13:4]), 32'd33);
    chk("R8 loaded vc avoided", 32'({lg_vc[3], lg_flit[3][13:4]}), 32'({1'b1, 10'd41}));
  endtask

  task automatic t_backpressure();
    do_reset();
    out_ready[3:2] = 2'b00;
    for (int k = 0; k < 4; k++) begin
      set_in(0, 1'b0, mk(2'b11, 2, 1, 50 + k));
      step();
    end
    chk("R2 full vc0", 32'(in_ready[0]), 32'h0);
    chk("R2 vc1 free", 32'(in_ready[1]), 32'h1);
    chk("R6 no valid", 32'(out_valid[1]), 32'h0);
    set_in(0, 1'b0, mk(2'b11, 2, 1, 99));
    step();
    out_ready = '1;
    idle(6);
    chk("R2 only four", 32'(lg_n), 32'd4);
    for (int k = 0; k < 4; k++)
      chk("R2 order", 32'(lg_flit[k][13:4]), 32'(50 + k));
  endtask

  task automatic t_stray();
    do_reset();
    set_in(0, 1'b1, mk(2'b00, 2, 1, 60));
    step();
    set_in(0, 1'b1, mk(2'b11, 1, 0, 61));
    step();
    idle(4);
    chk("R10 count", 32'(lg_n), 32'd1);
    chk("R10 port", 32'(lg_port[0]), 32'd4);
    chk("R10 flit", 32'(lg_flit[0][13:4]), 32'd61);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_route();
    t_worm();
    t_rr();
    t_load();
    t_backpressure();
    t_stray();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule